// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block keeps track of the operating mode of a small microcontroller and drives the clock enables for its peripherals. There are five modes: full run, low-power run, low-power wait, a light stop and a deep stop. The CPU sends single-cycle stop and wait strobes. Interrupts wake the part again. Software sets the low-power, wake-on-interrupt, debug and deep-stop control bits.

In the two low-power active modes, each peripheral clock enable follows its bit in two software-written gate registers. In full run every peripheral clock is on. Both stop modes turn every peripheral clock off, whatever the gate registers hold. Only the debug clock and the real-time counter clock can stay on in a stop mode, and each depends on its own enable bit. The deep stop raises a regulator low-power flag and an I/O hold flag. Leaving the deep stop is handled as a full restart: the block issues a one-cycle reset request.

Every enable and flag is registered from the mode of the previous cycle. Gated clocks therefore change only on a clock edge, one cycle after the mode changes.

Top module: `pmode_clkgate_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, the mode is full run (code 0). All peripheral enables are high, the debug clock enable is high, and the real-time counter enable, regulator flag, I/O hold and reset request are low.
- R2: The mode output uses these codes: full run 0, low-power run 1, low-power wait 2, light stop 3, deep stop 4. With no stop strobe, full run moves to low-power run when `lp_en` is 1. Low-power run moves back to full run when `lp_en` is 0 and there is no stop or wait strobe.
- R3: A stop strobe in full run or low-power run goes to deep stop if `stop_deep` is 1, and to light stop if it is 0. The stop strobe takes priority over every other input.
- R4: A wait strobe in low-power run goes to low-power wait, and takes priority over `lp_en` being 0. A wait strobe in full run has no effect. Any interrupt in low-power wait returns to low-power run.
- R5: An interrupt in light stop returns to full run when `lp_en` is 0 or `lp_wake_irq` is 1. It goes to low-power run when `lp_en` is 1 and `lp_wake_irq` is 0. Without an interrupt the light stop is held.
- R6: An interrupt in deep stop returns to full run. `rst_req` is high for exactly the one cycle in which the mode first shows full run again.
- R7: The peripheral enables are all ones in full run. In low-power run and low-power wait they equal `{gate_b, gate_a}`, with `gate_a` in the low bits. In both stop modes they are all zeros.
- R8: The debug clock enable is 1 in full run, 0 in the low-power active modes, and equal to `dbg_en` in both stop modes.
- R9: The real-time counter clock enable follows `rtc_en` in every mode, deep stop included.
- R10: `reg_lp` and `io_hold` are high exactly when the previous cycle's mode was deep stop.
- R11: Each output in R7 to R10 is registered from the mode and inputs of the previous cycle. It changes at the clock edge after the edge that changed the mode.
- R12: The light stop never raises `rst_req`. The blocks it puts on standby keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req | input | 1 | Stop strobe from the CPU |
| wait_req | input | 1 | Wait strobe from the CPU |
| irq | input | 1 | Any pending interrupt |
| lp_en | input | 1 | Low-power operation enable |
| lp_wake_irq | input | 1 | Leave light stop to full run on interrupt even in low-power operation |
| dbg_en | input | 1 | Keep debug clock in stop |
| stop_deep | input | 1 | Stop strobe selects deep stop |
| rtc_en | input | 1 | Real-time counter clock enable |
| gate_a | input | GA_W | Gate register A, low peripheral bits |
| gate_b | input | GB_W | Gate register B, high peripheral bits |
| mode | output | 3 | Current mode code |
| periph_clk_en | output | GA_W+GB_W | Per-peripheral clock enables |
| dbg_clk_en | output | 1 | Debug clock enable |
| rtc_clk_en | output | 1 | Real-time counter clock enable |
| reg_lp | output | 1 | Regulator partial power-down indication |
| io_hold | output | 1 | I/O pin states held |
| rst_req | output | 1 | One-cycle reset request on deep-stop exit |

## Verification
Several corner cases are targeted. An interrupt in light stop with `lp_en` high and `lp_wake_irq` low must land in low-power run; a decoder that ignores the wake bit would return to full run instead. A stop strobe arriving together with a wait strobe must win, or the part would stall in low-power wait. The cycle right after entering a stop mode must still show the previous enables; a design that gates combinationally would drop them one cycle early. In deep stop the gate registers are set to all ones, which exposes a design that lets them leak through. The `rst_req` pulse must last one cycle, and the light stop must never produce it.

// File: rtl/pmode_pkg.sv
// Package: shared mode encoding for the low-power clock gating controller.
// Assumes: 3-bit mode codes are decoded by neighbours, so values are fixed.
package pmode_pkg;
    typedef enum logic [2:0] {
        M_RUN    = 3'd0,
        M_LPRUN  = 3'd1,
        M_LPWAIT = 3'd2,
        M_STOP3  = 3'd3,
        M_STOP2  = 3'd4
    } mode_e;
endpackage

// File: rtl/pmode_fsm.sv
// Module: pmode_fsm
// Holds the operating mode and produces the deep-stop exit reset request.
// Assumes: stop/wait strobes and irq are synchronous to clk; rst_n is
// synchronous and active low.
module pmode_fsm
    import pmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stop_req,
    input  logic  wait_req,
    input  logic  irq,
    input  logic  lp_en,
    input  logic  lp_wake_irq,
    input  logic  stop_deep,
    output mode_e mode_q,
    output logic  rst_req
);
    mode_e mode_d;
    logic  leave_deep;
    mode_e stop_target;

    // Choose which stop mode a stop strobe enters.
    always_comb stop_target = stop_deep ? M_STOP2 : M_STOP3;

    // Next-mode decision; stop strobe has top priority in active modes.
    always_comb begin
        mode_d     = mode_q;
        leave_deep = 1'b0;
        case (mode_q)
            M_RUN: begin
                if (stop_req)   mode_d = stop_target;
                else if (lp_en) mode_d = M_LPRUN;
            end
            M_LPRUN: begin
                if (stop_req)      mode_d = stop_target;
                else if (wait_req) mode_d = M_LPWAIT;
                else if (!lp_en)   mode_d = M_RUN;
            end
            M_LPWAIT: begin
                if (irq) mode_d = M_LPRUN;
            end
            M_STOP3: begin
                if (irq) mode_d = (lp_en && !lp_wake_irq) ? M_LPRUN : M_RUN;
            end
            M_STOP2: begin
                if (irq) begin
                    mode_d     = M_RUN;
                    leave_deep = 1'b1;
                end
            end
            default: mode_d = M_RUN;
        endcase
    end

    // Mode register and one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= M_RUN;
            rst_req <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            rst_req <= leave_deep;
        end
    end

    a_r3_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == M_RUN || mode_q == M_LPRUN) && stop_req)
        |=> (mode_q == M_STOP3 || mode_q == M_STOP2));

    a_r5_stop3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_STOP3 && !irq) |=> (mode_q == M_STOP3));

    a_r6_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    a_r6_rst_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (mode_q == M_RUN));

    a_r12_stop3_no_rst: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_STOP3) |=> !rst_req);
endmodule

// File: rtl/pmode_gate.sv
// Module: pmode_gate
// Registers the peripheral, debug and real-time counter clock enables and
// the deep-stop flags from the current mode, so that every enable changes
// on a clock edge one cycle after the mode.
// Assumes: gate registers are static or change synchronously to clk.
module pmode_gate
    import pmode_pkg::*;
#(
    parameter int GA_W = 8,
    parameter int GB_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode_i,
    input  logic [GA_W-1:0]   gate_a,
    input  logic [GB_W-1:0]   gate_b,
    input  logic              dbg_en,
    input  logic              rtc_en,
    output logic [GA_W+GB_W-1:0] periph_en,
    output logic              dbg_clk_en,
    output logic              rtc_clk_en,
    output logic              reg_lp,
    output logic              io_hold
);
    localparam int NP = GA_W + GB_W;

    logic [NP-1:0] gate_all;
    logic          in_stop;
    logic          in_deep;

    // Concatenate the two gate registers, bank A in the low bits.
    always_comb gate_all = {gate_b, gate_a};

    // Decode stop membership from the mode.
    always_comb begin
        in_deep = (mode_i == M_STOP2);
        in_stop = in_deep || (mode_i == M_STOP3);
    end

    // Enable and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            periph_en  <= '1;
            dbg_clk_en <= 1'b1;
            rtc_clk_en <= 1'b0;
            reg_lp     <= 1'b0;
            io_hold    <= 1'b0;
        end else begin
            rtc_clk_en <= rtc_en;
            reg_lp     <= in_deep;
            io_hold    <= in_deep;
            if (in_stop) begin
                periph_en  <= '0;
                dbg_clk_en <= dbg_en;
            end else if (mode_i == M_RUN) begin
                periph_en  <= '1;
                dbg_clk_en <= 1'b1;
            end else begin
                periph_en  <= gate_all;
                dbg_clk_en <= 1'b0;
            end
        end
    end

    a_r7_stop_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        in_stop |=> (periph_en == '0));

    a_r8_dbg_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop && dbg_en) |=> dbg_clk_en);

    a_r10_hold_with_lp: assert property (@(posedge clk) disable iff (!rst_n)
        io_hold |-> reg_lp);

    a_r9_rtc_follow: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_en |=> rtc_clk_en);
endmodule

// File: rtl/pmode_clkgate_ctrl.sv
// Module: pmode_clkgate_ctrl (top)
// Mode tracker plus clock-enable generator for a small microcontroller.
// Assumes: single clock domain, synchronous active-low reset.
module pmode_clkgate_ctrl
    import pmode_pkg::*;
#(
    parameter int GA_W = 8,
    parameter int GB_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stop_req,
    input  logic                 wait_req,
    input  logic                 irq,
    input  logic                 lp_en,
    input  logic                 lp_wake_irq,
    input  logic                 dbg_en,
    input  logic                 stop_deep,
    input  logic                 rtc_en,
    input  logic [GA_W-1:0]      gate_a,
    input  logic [GB_W-1:0]      gate_b,
    output logic [2:0]           mode,
    output logic [GA_W+GB_W-1:0] periph_clk_en,
    output logic                 dbg_clk_en,
    output logic                 rtc_clk_en,
    output logic                 reg_lp,
    output logic                 io_hold,
    output logic                 rst_req
);
    mode_e mode_cur;

    // Mode state machine.
    pmode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_req    (stop_req),
        .wait_req    (wait_req),
        .irq         (irq),
        .lp_en       (lp_en),
        .lp_wake_irq (lp_wake_irq),
        .stop_deep   (stop_deep),
        .mode_q      (mode_cur),
        .rst_req     (rst_req)
    );

    // Clock enable generation.
    pmode_gate #(.GA_W(GA_W), .GB_W(GB_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_cur),
        .gate_a     (gate_a),
        .gate_b     (gate_b),
        .dbg_en     (dbg_en),
        .rtc_en     (rtc_en),
        .periph_en  (periph_clk_en),
        .dbg_clk_en (dbg_clk_en),
        .rtc_clk_en (rtc_clk_en),
        .reg_lp     (reg_lp),
        .io_hold    (io_hold)
    );

    // Publish the mode code.
    always_comb mode = mode_cur;
endmodule

// File: tb/pmode_clkgate_ctrl_bench.sv
// Bench: behavioural reference model compared every clock, plus directed
// corner-case checks.
module pmode_clkgate_ctrl_bench;
    localparam int GA_W = 8;
    localparam int GB_W = 8;
    localparam int NP   = GA_W + GB_W;

    logic clk = 1'b0;
    logic rst_n, stop_req, wait_req, irq, lp_en, lp_wake_irq;
    logic dbg_en, stop_deep, rtc_en;
    logic [GA_W-1:0] gate_a;
    logic [GB_W-1:0] gate_b;
    logic [2:0]      mode;
    logic [NP-1:0]   periph_clk_en;
    logic dbg_clk_en, rtc_clk_en, reg_lp, io_hold, rst_req;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // reference model state
    int          m_mode;
    logic [NP-1:0] m_pe;
    logic m_dbg, m_rtc, m_lp, m_hold, m_rr;

    always #4 clk = ~clk;

    pmode_clkgate_ctrl #(.GA_W(GA_W), .GB_W(GB_W)) u_pmode_clkgate_ctrl (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wait_req(wait_req),
        .irq(irq), .lp_en(lp_en), .lp_wake_irq(lp_wake_irq), .dbg_en(dbg_en),
        .stop_deep(stop_deep), .rtc_en(rtc_en), .gate_a(gate_a), .gate_b(gate_b),
        .mode(mode), .periph_clk_en(periph_clk_en), .dbg_clk_en(dbg_clk_en),
        .rtc_clk_en(rtc_clk_en), .reg_lp(reg_lp), .io_hold(io_hold),
        .rst_req(rst_req)
    );

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Reference model step, using the inputs present at this edge.
    task automatic model_step();
        int nm;
        if (!rst_n) begin
            m_mode = 0; m_pe = '1; m_dbg = 1; m_rtc = 0; m_lp = 0; m_hold = 0; m_rr = 0;
            return;
        end
        m_rtc  = rtc_en;
        m_lp   = (m_mode == 4);
        m_hold = (m_mode == 4);
        if (m_mode >= 3) begin m_pe = '0; m_dbg = dbg_en; end
        else if (m_mode == 0) begin m_pe = '1; m_dbg = 1; end
        else begin m_pe = {gate_b, gate_a}; m_dbg = 0; end
        nm = m_mode;
        m_rr = 0;
        if (m_mode == 0) begin
            if (stop_req) nm = stop_deep ? 4 : 3;
            else if (lp_en) nm = 1;
        end else if (m_mode == 1) begin
            if (stop_req) nm = stop_deep ? 4 : 3;
            else if (wait_req) nm = 2;
            else if (!lp_en) nm = 0;
        end else if (m_mode == 2) begin
            if (irq) nm = 1;
        end else if (m_mode == 3) begin
            if (irq) nm = (lp_en && !lp_wake_irq) ? 1 : 0;
        end else begin
            if (irq) begin nm = 0; m_rr = 1; end
        end
        m_mode = nm;
    endtask

    task automatic compare();
        chk(mode == 3'(m_mode), "R2 mode", mode, m_mode);
        chk(periph_clk_en == m_pe, "R7 periph_clk_en", periph_clk_en, m_pe);
        chk(dbg_clk_en == m_dbg, "R8 dbg_clk_en", dbg_clk_en, m_dbg);
        chk(rtc_clk_en == m_rtc, "R9 rtc_clk_en", rtc_clk_en, m_rtc);
        chk(reg_lp == m_lp && io_hold == m_hold, "R10 reg_lp/io_hold",
            {reg_lp, io_hold}, {m_lp, m_hold});
        chk(rst_req == m_rr, "R6 rst_req", rst_req, m_rr);
    endtask

    // One cycle: inputs already driven; clock edge, model, sample at negedge.
    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        cyc++;
        compare();
    endtask

    task automatic idle_inputs();
        stop_req = 0; wait_req = 0; irq = 0;
    endtask

    initial begin
        rst_n = 0; lp_en = 0; lp_wake_irq = 0; dbg_en = 0; stop_deep = 0;
        rtc_en = 0; gate_a = 8'h5A; gate_b = 8'hC3;
        idle_inputs();
        m_mode = 0; m_pe = '1; m_dbg = 1; m_rtc = 0; m_lp = 0; m_hold = 0; m_rr = 0;
        step(); step();
        // R1 reset state
        chk(mode == 3'd0 && periph_clk_en == '1 && dbg_clk_en && !rst_req
            && !io_hold && !reg_lp && !rtc_clk_en, "R1 reset state",
            {mode, dbg_clk_en, rst_req}, {3'd0, 1'b1, 1'b0});
        rst_n = 1;
        step();

        // R4: wait strobe in full run is ignored
        wait_req = 1; step(); wait_req = 0;
        chk(mode == 3'd0, "R4 wait in run ignored", mode, 0);

        // R3 + R11: stop strobe (with wait) enters light stop; enables lag a cycle
        stop_req = 1; wait_req = 1; stop_deep = 0; step(); idle_inputs();
        chk(mode == 3'd3, "R3 stop to light stop", mode, 3);
        chk(periph_clk_en == '1, "R11 enables lag mode", periph_clk_en, '1);
        dbg_en = 1; step();
        chk(periph_clk_en == '0, "R7 stop gates off", periph_clk_en, 0);
        chk(dbg_clk_en == 1'b1, "R8 debug kept in stop", dbg_clk_en, 1);
        step(); step();
        chk(rst_req == 1'b0, "R12 no reset from light stop", rst_req, 0);

        // R5: interrupt with lp_en=1, lp_wake_irq=0 lands in low-power run
        lp_en = 1; lp_wake_irq = 0; irq = 1; step(); irq = 0;
        chk(mode == 3'd1, "R5 light stop to low-power run", mode, 1);
        chk(rst_req == 1'b0, "R12 no reset on light stop exit", rst_req, 0);
        step();
        chk(periph_clk_en == {gate_b, gate_a}, "R7 gates in low-power run",
            periph_clk_en, {gate_b, gate_a});

        // R4: wait then interrupt
        wait_req = 1; lp_en = 0; step(); wait_req = 0;
        chk(mode == 3'd2, "R4 wait strobe to low-power wait", mode, 2);
        irq = 1; step(); irq = 0; lp_en = 1;
        chk(mode == 3'd1, "R4 irq to low-power run", mode, 1);

        // R5: interrupt with wake bit set returns to full run
        stop_req = 1; step(); idle_inputs();
        lp_wake_irq = 1; irq = 1; step(); irq = 0; lp_en = 0;
        chk(mode == 3'd0, "R5 wake bit returns to run", mode, 0);

        // R6/R10: deep stop with all-ones gates, then wake
        gate_a = '1; gate_b = '1; rtc_en = 1; dbg_en = 0;
        stop_req = 1; stop_deep = 1; step(); idle_inputs();
        chk(mode == 3'd4, "R3 stop to deep stop", mode, 4);
        step();
        chk(periph_clk_en == '0 && io_hold && reg_lp, "R10 deep stop flags",
            {periph_clk_en, io_hold}, {16'h0, 1'b1});
        chk(rtc_clk_en == 1'b1, "R9 rtc in deep stop", rtc_clk_en, 1);
        irq = 1; step(); irq = 0;
        chk(rst_req == 1'b1 && mode == 3'd0, "R6 reset request on deep exit",
            {rst_req, mode}, {1'b1, 3'd0});
        step();
        chk(rst_req == 1'b0, "R6 reset request one cycle", rst_req, 0);

        // Random phase compared against the model each cycle
        for (int i = 0; i < 4000; i++) begin
            rst_n       = ($urandom % 300) != 0;
            stop_req    = ($urandom % 7) == 0;
            wait_req    = ($urandom % 4) == 0;
            irq         = ($urandom % 5) == 0;
            lp_en       = ($urandom % 3) != 0;
            lp_wake_irq = $urandom % 2;
            dbg_en      = $urandom % 2;
            stop_deep   = $urandom % 2;
            rtc_en      = $urandom % 2;
            gate_a      = GA_W'($urandom);
            gate_b      = GB_W'($urandom);
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule